// File: doc/BRIEF.md
# Reordering DRAM Command Scheduler

This block keeps a short queue of pending DRAM read and write requests and picks, each cycle, the one to present on its issue port. The choice is not arrival order. A request whose row is already open is favoured when it keeps the data bus in the direction of the last issued command. A request that carries the user urgency flag is favoured over both. A bypass counter on every waiting entry puts a bound on how long a disfavoured request can wait. Once that counter reaches a programmable limit, the entry is issued next, whatever the other entries are.

Requests enter through a valid/ready port. Each request carries an address, a read/write bit, an urgency flag and a close-page flag. Commands leave through a valid/ready issue port. The open-row state is supplied from outside as one row-hit bit per bank. DRAM timing, the physical interface and the data path live elsewhere.

Top module: `reorder_sched`

## Requirements
- R1: While reset is low and on the first cycle after it, `iss_valid` is 0 and `req_ready` is 1. The queue is empty and the bus direction is taken as read.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. It can appear on the issue port from the next cycle. `req_ready` is 0 exactly when DEPTH entries are held.
- R3: An entry whose bypass count is at least the effective limit is "starved". If any eligible entry is starved, the oldest starved entry is issued, ahead of urgency and row-hit preference.
- R4: The effective limit is `starve_lim` (8 bits) clamped into 1..63: 0 acts as 1, and any value above 63 acts as 63.
- R5: When no entry is starved, the oldest eligible entry with `req_hipri`=1 is chosen over every entry without it.
- R6: When no entry is starved or urgent, the oldest eligible entry is chosen whose bank row-hit bit is 1 and whose direction (`wr`) equals that of the last issued command.
- R7: When no earlier rule selects an entry, the oldest eligible entry is issued.
- R8: A read and a write to the same address never pass each other. The younger of the two is ineligible until the older one has issued.
- R9: `iss_addr`, `iss_wr` and `iss_ap` equal the address, direction and close-page flag the request was accepted with.
- R10: On each issue, the bypass count of every entry older than the issued one rises by one, saturating at 63. With a constant stream of favoured requests, an older row-miss request issues in issue slot limit+1.
- R11: The bank of a request is `addr[BANK_W-1:0]`, where BANK_W = log2(BANKS). It selects bit `bank_hit[bank]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| starve_lim | input | 8 | Bypass limit before an entry is forced out, clamped to 1..63 |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can accept a request |
| req_addr | input | ADDR_W | Request address; low bits give the bank |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_hipri | input | 1 | Urgency flag |
| req_ap | input | 1 | Close-page-after-access flag |
| bank_hit | input | BANKS | Per-bank open-row hit indication |
| iss_valid | output | 1 | A command is presented |
| iss_ready | input | 1 | Downstream takes the command |
| iss_addr | output | ADDR_W | Address of the presented command |
| iss_wr | output | 1 | Direction of the presented command |
| iss_ap | output | 1 | Close-page flag of the presented command |

## Verification
A request accepted at one rising edge is visible on the issue outputs from the following falling edge. An issue handshake at a rising edge removes the entry and updates the bypass counts and the bus direction, so the next choice is visible at the following falling edge. The bench drives inputs just after rising edges. It samples only at falling edges, one step after each handshake it makes. For the starvation bound, it numbers every issue handshake in a continuous stream and compares the slot in which the row-miss request appears against the clamped limit plus one.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;
  localparam int AGE_W    = 6;
  localparam int LIM_IN_W = 8;
  typedef logic [AGE_W-1:0] age_t;
  localparam age_t LIM_LO = age_t'(1);
  localparam age_t LIM_HI = age_t'(63);

  // effective starvation limit
  function automatic age_t clamp_limit(input logic [LIM_IN_W-1:0] raw);
    if (raw < LIM_IN_W'(LIM_LO)) return LIM_LO;
    if (raw > LIM_IN_W'(LIM_HI)) return LIM_HI;
    return raw[AGE_W-1:0];
  endfunction

  // saturating bypass count step
  function automatic age_t age_bump(input age_t a);
    return (a == LIM_HI) ? a : a + age_t'(1);
  endfunction
endpackage

// File: rtl/sched_queue.sv
`timescale 1ns/1ps
// Compacted arrival-ordered store: slot 0 is always the oldest entry.
module sched_queue
  import sched_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [ADDR_W-1:0]             push_addr,
  input  logic                          push_wr,
  input  logic                          push_hi,
  input  logic                          push_ap,
  input  logic                          pop,
  input  logic [IDX_W-1:0]              pop_idx,
  output logic [CNT_W-1:0]              count,
  output logic [DEPTH-1:0][ADDR_W-1:0]  q_addr,
  output logic [DEPTH-1:0]              q_wr,
  output logic [DEPTH-1:0]              q_hi,
  output logic [DEPTH-1:0]              q_ap,
  output age_t [DEPTH-1:0]              q_age
);
  logic [CNT_W-1:0] wpos;
  assign wpos = pop ? count - CNT_W'(1) : count;

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else begin
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [ADDR_W-1:0] nx_addr, up_addr;
    logic              nx_wr, nx_hi, nx_ap, up_wr, up_hi, up_ap;
    age_t              nx_age, up_age;
    logic              shift_in, older_than_pop;

    // neighbour above, or empty for the top slot
    if (i < DEPTH - 1) begin : g_up
      assign up_addr = q_addr[i+1];
      assign up_wr   = q_wr[i+1];
      assign up_hi   = q_hi[i+1];
      assign up_ap   = q_ap[i+1];
      assign up_age  = q_age[i+1];
    end else begin : g_top
      assign up_addr = '0;
      assign up_wr   = 1'b0;
      assign up_hi   = 1'b0;
      assign up_ap   = 1'b0;
      assign up_age  = '0;
    end

    assign shift_in       = pop && (IDX_W'(i) >= pop_idx);
    assign older_than_pop = pop && (IDX_W'(i) <  pop_idx);

    always_comb begin
      if (shift_in) begin
        nx_addr = up_addr; nx_wr = up_wr; nx_hi = up_hi; nx_ap = up_ap; nx_age = up_age;
      end else begin
        nx_addr = q_addr[i]; nx_wr = q_wr[i]; nx_hi = q_hi[i]; nx_ap = q_ap[i];
        nx_age  = older_than_pop ? age_bump(q_age[i]) : q_age[i];
      end
      if (push && (CNT_W'(i) == wpos)) begin
        nx_addr = push_addr; nx_wr = push_wr; nx_hi = push_hi; nx_ap = push_ap;
        nx_age  = '0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q_addr[i] <= '0; q_wr[i] <= 1'b0; q_hi[i] <= 1'b0; q_ap[i] <= 1'b0; q_age[i] <= '0;
      end else begin
        q_addr[i] <= nx_addr; q_wr[i] <= nx_wr; q_hi[i] <= nx_hi;
        q_ap[i]   <= nx_ap;   q_age[i] <= nx_age;
      end
    end
  end
endmodule

// File: rtl/sched_pick.sv
`timescale 1ns/1ps
// Combinational choice among queued entries.
module sched_pick
  import sched_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int BANKS  = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic [CNT_W-1:0]              count,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  q_addr,
  input  logic [DEPTH-1:0]              q_wr,
  input  logic [DEPTH-1:0]              q_hi,
  input  age_t [DEPTH-1:0]              q_age,
  input  logic [BANKS-1:0]              bank_hit,
  input  age_t                          limit,
  input  logic                          last_wr,
  output logic                          sel_valid,
  output logic [IDX_W-1:0]              sel_idx,
  output logic [DEPTH-1:0]              starved_vec,
  output logic [DEPTH-1:0]              urgent_vec,
  output logic [DEPTH-1:0]              blocked_vec
);
  logic [DEPTH-1:0] vld, elig, dirhit;

  function automatic logic [IDX_W-1:0] first_set(input logic [DEPTH-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = DEPTH - 1; k >= 0; k--) if (v[k]) r = IDX_W'(k);
    return r;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [BANK_W-1:0] bank;
    assign bank           = q_addr[i][BANK_W-1:0];
    assign vld[i]         = CNT_W'(i) < count;
    assign elig[i]        = vld[i] && !blocked_vec[i];
    assign starved_vec[i] = elig[i] && (q_age[i] >= limit);
    assign urgent_vec[i]  = elig[i] && q_hi[i];
    assign dirhit[i]      = elig[i] && bank_hit[bank] && (q_wr[i] == last_wr);
  end

  // same address, opposite direction, older entry present
  always_comb begin
    blocked_vec = '0;
    for (int i = 0; i < DEPTH; i++)
      for (int j = 0; j < i; j++)
        if (vld[i] && vld[j] && (q_addr[i] == q_addr[j]) && (q_wr[i] != q_wr[j]))
          blocked_vec[i] = 1'b1;
  end

  assign sel_valid = |elig;

  always_comb begin
    if (|starved_vec)     sel_idx = first_set(starved_vec);
    else if (|urgent_vec) sel_idx = first_set(urgent_vec);
    else if (|dirhit)     sel_idx = first_set(dirhit);
    else                  sel_idx = first_set(elig);
  end
endmodule

// File: rtl/reorder_sched.sv
`timescale 1ns/1ps
module reorder_sched
  import sched_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int BANKS  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LIM_IN_W-1:0]  starve_lim,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_wr,
  input  logic                 req_hipri,
  input  logic                 req_ap,
  input  logic [BANKS-1:0]     bank_hit,
  output logic                 iss_valid,
  input  logic                 iss_ready,
  output logic [ADDR_W-1:0]    iss_addr,
  output logic                 iss_wr,
  output logic                 iss_ap
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]              count;
  logic [DEPTH-1:0][ADDR_W-1:0]  q_addr;
  logic [DEPTH-1:0]              q_wr, q_hi, q_ap;
  age_t [DEPTH-1:0]              q_age;
  logic [IDX_W-1:0]              sel_idx;
  logic [DEPTH-1:0]              starved_vec, urgent_vec, blocked_vec;
  logic                          sel_valid, last_wr;
  age_t                          limit;

  // named events for the checker
  logic push_fire, issue_fire;
  logic any_starved, sel_starved, any_urgent, sel_urgent, sel_blocked;

  assign limit      = clamp_limit(starve_lim);
  assign req_ready  = count < CNT_W'(DEPTH);
  assign push_fire  = req_valid && req_ready;
  assign iss_valid  = sel_valid;
  assign issue_fire = iss_valid && iss_ready;
  assign iss_addr   = q_addr[sel_idx];
  assign iss_wr     = q_wr[sel_idx];
  assign iss_ap     = q_ap[sel_idx];

  assign any_starved = |starved_vec;
  assign sel_starved = starved_vec[sel_idx];
  assign any_urgent  = |urgent_vec;
  assign sel_urgent  = q_hi[sel_idx];
  assign sel_blocked = blocked_vec[sel_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)          last_wr <= 1'b0;
    else if (issue_fire) last_wr <= iss_wr;
  end

  sched_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push_fire), .push_addr(req_addr), .push_wr(req_wr),
    .push_hi(req_hipri), .push_ap(req_ap),
    .pop(issue_fire), .pop_idx(sel_idx),
    .count(count), .q_addr(q_addr), .q_wr(q_wr), .q_hi(q_hi),
    .q_ap(q_ap), .q_age(q_age)
  );

  sched_pick #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BANKS(BANKS)) u_pick (
    .count(count), .q_addr(q_addr), .q_wr(q_wr), .q_hi(q_hi), .q_age(q_age),
    .bank_hit(bank_hit), .limit(limit), .last_wr(last_wr),
    .sel_valid(sel_valid), .sel_idx(sel_idx),
    .starved_vec(starved_vec), .urgent_vec(urgent_vec), .blocked_vec(blocked_vec)
  );
endmodule

// File: rtl/sched_chk.sv
`timescale 1ns/1ps
module sched_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic             iss_valid,
  input logic             push_fire,
  input logic             issue_fire,
  input logic             any_starved,
  input logic             sel_starved,
  input logic             any_urgent,
  input logic             sel_urgent,
  input logic             sel_blocked
);
  a_r1_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !iss_valid);

  a_r2_count_track: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (count == $past(count) + CNT_W'($past(push_fire)) - CNT_W'($past(issue_fire))));

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  a_r3_starved_first: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && any_starved) |-> sel_starved);

  a_r5_urgent_first: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !any_starved && any_urgent) |-> sel_urgent);

  a_r8_order_kept: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !sel_blocked);
endmodule

bind reorder_sched sched_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .iss_valid(iss_valid),
  .push_fire(push_fire), .issue_fire(issue_fire),
  .any_starved(any_starved), .sel_starved(sel_starved),
  .any_urgent(any_urgent), .sel_urgent(sel_urgent), .sel_blocked(sel_blocked)
);

// File: tb/tb_reorder_sched.sv
`timescale 1ns/1ps
module tb_reorder_sched;
  localparam int DEPTH = 8, ADDR_W = 16, BANKS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] starve_lim = 8'd63;
  logic req_valid = 1'b0, req_wr = 1'b0, req_hipri = 1'b0, req_ap = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [BANKS-1:0] bank_hit = '0;
  logic iss_ready = 1'b0;
  logic req_ready, iss_valid, iss_wr, iss_ap;
  logic [ADDR_W-1:0] iss_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  reorder_sched #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BANKS(BANKS)) dut (
    .clk(clk), .rst_n(rst_n), .starve_lim(starve_lim),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wr(req_wr), .req_hipri(req_hipri), .req_ap(req_ap),
    .bank_hit(bank_hit), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_addr(iss_addr), .iss_wr(iss_wr), .iss_ap(iss_ap)
  );

  always #2.5 clk = ~clk;

  // {a_addr, a_wr, a_hi, b_addr, b_wr, b_hi, bank_hit, expect_b}
  localparam int NV = 8;
  localparam logic [40:0] VEC [NV] = '{
    {16'h0011, 1'b0, 1'b0, 16'h0022, 1'b0, 1'b0, 4'b0000, 1'b0},  // R7 oldest
    {16'h0011, 1'b0, 1'b0, 16'h0022, 1'b1, 1'b1, 4'b0000, 1'b1},  // R5 urgent younger
    {16'h0011, 1'b0, 1'b1, 16'h0022, 1'b0, 1'b1, 4'b0000, 1'b0},  // R5 both urgent
    {16'h0011, 1'b0, 1'b0, 16'h0022, 1'b0, 1'b0, 4'b0100, 1'b1},  // R6 read hit
    {16'h0011, 1'b0, 1'b0, 16'h0022, 1'b1, 1'b0, 4'b0100, 1'b0},  // R6 hit wrong dir
    {16'h0030, 1'b1, 1'b0, 16'h0030, 1'b0, 1'b1, 4'b0001, 1'b0},  // R8 same address
    {16'h0013, 1'b0, 1'b0, 16'h0020, 1'b1, 1'b1, 4'b1000, 1'b1},  // R5 over hit
    {16'h0012, 1'b0, 1'b0, 16'h0101, 1'b0, 1'b0, 4'b0010, 1'b1}   // R11 bank bits
  };
  string vtag [NV] = '{"R7", "R5", "R5", "R6", "R6", "R8", "R5", "R11"};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; iss_ready = 1'b0; bank_hit = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [ADDR_W-1:0] a, input bit w, input bit h, input bit p);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_wr = w; req_hipri = h; req_ap = p;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic pop_one();
    @(negedge clk);
    iss_ready = 1'b1;
    @(posedge clk);
    #1 iss_ready = 1'b0;
  endtask

  // R10 / R3 / R4: slot in which an older row-miss leaves a stream of hits
  task automatic run_starve(input logic [7:0] lim, input bit hi, input int exp_slot, input string tag);
    int k, got;
    do_reset();
    starve_lim = lim;
    bank_hit = 4'b0001;
    push(16'h0101, 1'b0, 1'b0, 1'b0);
    for (int n = 1; n <= 3; n++) push(16'(n * 4), 1'b0, hi, 1'b0);
    k = 4; got = 0;
    @(negedge clk);
    iss_ready = 1'b1; req_valid = 1'b1; req_wr = 1'b0; req_hipri = hi; req_ap = 1'b0;
    req_addr = 16'(k * 4);
    for (int s = 1; s <= 80 && got == 0; s++) begin
      if (iss_valid && iss_addr == 16'h0101) got = s;
      @(posedge clk);
      #1 k++;
      req_addr = 16'(k * 4);
      @(negedge clk);
    end
    iss_ready = 1'b0; req_valid = 1'b0;
    chk(got == exp_slot, tag, got, exp_slot);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [40:0] v;
    logic [ADDR_W-1:0] first_a, second_a;

    // R1: reset state
    do_reset();
    chk(!iss_valid, "R1 iss_valid", iss_valid, 0);
    chk(req_ready, "R1 req_ready", req_ready, 1);
    push(16'h0055, 1'b0, 1'b0, 1'b0);
    do_reset();
    chk(!iss_valid, "R1 flush on reset", iss_valid, 0);

    // vector table: two requests, which one leaves first, then the other
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      do_reset();
      starve_lim = 8'd63;
      bank_hit = v[4:1];
      push(v[40:25], v[24], v[23], 1'b0);
      push(v[22:7], v[6], v[5], 1'b0);
      first_a  = v[0] ? v[22:7] : v[40:25];
      second_a = v[0] ? v[40:25] : v[22:7];
      @(negedge clk);
      chk(iss_valid && iss_addr == first_a, vtag[i], iss_addr, first_a);
      pop_one();
      @(negedge clk);
      chk(iss_valid && iss_addr == second_a, vtag[i], iss_addr, second_a);
      pop_one();
      @(negedge clk);
      chk(!iss_valid, "R7 drained", iss_valid, 0);
    end

    // R2: latency and full flag
    do_reset();
    push(16'h0044, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk(iss_valid && iss_addr == 16'h0044, "R2 one-cycle latency", iss_addr, 16'h0044);
    for (int n = 1; n < DEPTH; n++) push(16'(16'h0100 + n * 4), 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk(!req_ready, "R2 full", req_ready, 0);
    pop_one();
    @(negedge clk);
    chk(req_ready, "R2 space after issue", req_ready, 1);

    // R9: fields carried unchanged
    do_reset();
    push(16'hBEE4, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk(iss_addr == 16'hBEE4 && iss_wr && iss_ap, "R9 write+ap",
        {iss_addr, iss_wr, iss_ap}, {16'hBEE4, 2'b11});
    pop_one();
    push(16'h1238, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk(iss_addr == 16'h1238 && !iss_wr && !iss_ap, "R9 read",
        {iss_addr, iss_wr, iss_ap}, {16'h1238, 2'b00});

    // R6: direction follows the last issued command (a write)
    do_reset();
    push(16'h0040, 1'b1, 1'b0, 1'b0);
    pop_one();
    bank_hit = 4'b0110;
    push(16'h0011, 1'b0, 1'b0, 1'b0);
    push(16'h0022, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk(iss_addr == 16'h0022, "R6 write direction kept", iss_addr, 16'h0022);

    // R10 bound, R4 clamping, R3 over urgency
    run_starve(8'd3,   1'b0, 4,  "R10 limit 3");
    run_starve(8'd0,   1'b0, 2,  "R4 limit 0 acts as 1");
    run_starve(8'd200, 1'b0, 64, "R4 limit 200 acts as 63");
    run_starve(8'd5,   1'b1, 6,  "R3 starved beats urgent");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule